// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

A memory-mapped peripheral that lets a host processor and several co-processors exchange 32-bit words through six independent hardware queues. One side writes a word to a mailbox's message register, and the word is appended to that mailbox's queue. The other side reads the same register to take the oldest word out. Per-mailbox status registers report whether the queue is full and how many words it holds.

Each of four users has a write-one-to-clear event register, a mask register and a level interrupt output. Every mailbox produces two events: one when a word is accepted and one when a read frees a slot in a full queue. Software chooses which events reach each user's interrupt line.

Access is a single-cycle register port. Read data is combinational from the current state. A read of a message register dequeues on the clock edge at which it is presented.

Top module: `mbx_regbank`

## Requirements
- R1: After reset every queue is empty. Every event, mask and configuration bit is zero, and every irq_o line is low.
- R2: Address 0x00 reads the REV_VALUE parameter. Writes to it have no effect.
- R3: Address 0x10 stores bits 0 and 4 of a write. Every other bit reads 0. Address 0x14 reads the constant 1.
- R4: A write to 0x40+4n appends the word to queue n. A read of 0x40+4n returns the oldest word of queue n and removes it. The order is first-in first-out, and the queues do not affect each other.
- R5: Address 0xC0+4n reads the number of words in queue n, from 0 to DEPTH (4 by default).
- R6: Address 0x80+4n reads 1 when queue n holds DEPTH words and 0 otherwise.
- R7: A write to a full queue is discarded. A read of an empty queue returns 0 and changes nothing.
- R8: An accepted write to queue n sets bit 2n of every user's event register (user u at 0x100+8u). A read that takes queue n from full to not full sets bit 2n+1. Writes that are discarded and reads of an empty queue set no bit.
- R9: A write to an event register clears each bit written as 1 and leaves each bit written as 0 unchanged. If an event arrives in the same cycle as the clear, the bit stays set.
- R10: The mask register of user u is at 0x104+8u. It holds the 12 bits written and reads them back. irq_o[u] is high exactly when some bit is set in both the event register and the mask register of user u.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R12: When we_i and re_i are both high, the access is a write only. No word is dequeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (9) | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe; dequeues on message registers |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | NUM_USERS (4) | Level interrupt, one per user |

## Verification
Two things happen in the same cycle on a read of a full queue. The register returns the oldest word, and the not-full event is raised in all four users' event registers. The bench fills queues to DEPTH, which also tests discarded writes. It then reads them, and the reference model predicts both the data and the event bits. Random event clears are mixed with message traffic so that irq_o tracks the event and mask state after every access. A combined write and read strobe on a message register must leave the queue one word longer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned REV_ADDR   = 32'h000;
  localparam int unsigned SYSC_ADDR  = 32'h010;
  localparam int unsigned SSTAT_ADDR = 32'h014;
  localparam int unsigned MSG_BASE   = 32'h040;
  localparam int unsigned FSTAT_BASE = 32'h080;
  localparam int unsigned MSTAT_BASE = 32'h0C0;
  localparam int unsigned IRQ_BASE   = 32'h100;
  localparam logic [31:0] SYSC_MASK  = 32'h0000_0011;

  typedef enum logic [3:0] {
    K_NONE, K_REV, K_SYSC, K_SSTAT, K_MSG, K_FSTAT, K_MSTAT, K_IRQST, K_IRQEN
  } reg_kind_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
  output logic                         full_o,
  output logic                         push_ok_o,
  output logic                         unfull_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o    = (cnt == CW'(DEPTH));
  assign push_ok_o = push_i && !full_o;
  assign pop_ok    = pop_i && (cnt != '0);
  assign unfull_o  = pop_ok && full_o;
  assign head_o    = (cnt != '0) ? mem[rp] : '0;
  assign cnt_o     = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok_o) wp <= nxt(wp);
      if (pop_ok)    rp <= nxt(rp);
      cnt <= cnt + CW'(push_ok_o) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem[wp] <= wdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH)); // R5
  AST_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> full_o); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt == '0) |=> cnt == '0); // R7
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> cnt == $past(cnt) + CW'(1)); // R4
endmodule

// File: rtl/mbx_irq_user.sv
module mbx_irq_user #(
  parameter int NB = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] ev_i,
  input  logic          st_we_i,
  input  logic          en_we_i,
  input  logic [NB-1:0] wdata_i,
  output logic [NB-1:0] st_o,
  output logic [NB-1:0] en_o,
  output logic          irq_o
);
  logic [NB-1:0] clr;
  assign clr = st_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o <= '0;
      en_o <= '0;
    end else begin
      st_o <= (st_o & ~clr) | ev_i;  // event wins over clear
      if (en_we_i) en_o <= wdata_i;
    end
  end

  assign irq_o = |(st_o & en_o);

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_i |=> (st_o & $past(wdata_i & ~ev_i)) == '0); // R9
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> (st_o & $past(ev_i)) == $past(ev_i)); // R9
  AST_ST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_we_i && ev_i == '0) |=> $stable(st_o)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0) |-> !irq_o); // R10
endmodule

// File: rtl/mbx_regbank.sv
module mbx_regbank
  import mbx_pkg::*;
#(
  parameter int          NUM_MBOX  = 6,
  parameter int          NUM_USERS = 4,
  parameter int          DEPTH     = 4,
  parameter int          ADDR_W    = 9,
  parameter logic [31:0] REV_VALUE = 32'h0000_0021
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [31:0]          wdata_i,
  input  logic                 re_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_USERS-1:0] irq_o
);
  localparam int NB = 2 * NUM_MBOX;
  localparam int CW = $clog2(DEPTH+1);
  localparam int IW = $clog2(NUM_MBOX + NUM_USERS);

  reg_kind_e     kind;
  logic [IW-1:0] idx;
  logic          wr, rd;

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    if (addr_i == ADDR_W'(REV_ADDR))   kind = K_REV;
    if (addr_i == ADDR_W'(SYSC_ADDR))  kind = K_SYSC;
    if (addr_i == ADDR_W'(SSTAT_ADDR)) kind = K_SSTAT;
    for (int n = 0; n < NUM_MBOX; n++) begin
      if (addr_i == ADDR_W'(MSG_BASE + 4*n))   begin kind = K_MSG;   idx = IW'(n); end
      if (addr_i == ADDR_W'(FSTAT_BASE + 4*n)) begin kind = K_FSTAT; idx = IW'(n); end
      if (addr_i == ADDR_W'(MSTAT_BASE + 4*n)) begin kind = K_MSTAT; idx = IW'(n); end
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (addr_i == ADDR_W'(IRQ_BASE + 8*u))     begin kind = K_IRQST; idx = IW'(u); end
      if (addr_i == ADDR_W'(IRQ_BASE + 8*u + 4)) begin kind = K_IRQEN; idx = IW'(u); end
    end
  end

  assign wr = we_i;
  assign rd = re_i && !we_i;  // write takes the cycle

  logic [31:0]   head [NUM_MBOX];
  logic [CW-1:0] cnt  [NUM_MBOX];
  logic [NUM_MBOX-1:0] full, push_ok, unfull;
  logic [NB-1:0] ev;

  for (genvar n = 0; n < NUM_MBOX; n++) begin : g_mbox
    logic push, pop;
    assign push = wr && kind == K_MSG && idx == IW'(n);
    assign pop  = rd && kind == K_MSG && idx == IW'(n);
    mbx_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push),
      .wdata_i   (wdata_i),
      .pop_i     (pop),
      .head_o    (head[n]),
      .cnt_o     (cnt[n]),
      .full_o    (full[n]),
      .push_ok_o (push_ok[n]),
      .unfull_o  (unfull[n])
    );
    assign ev[2*n]   = push_ok[n];
    assign ev[2*n+1] = unfull[n];
  end

  logic [NB-1:0] st [NUM_USERS];
  logic [NB-1:0] en [NUM_USERS];

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    mbx_irq_user #(.NB(NB)) u_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ev_i    (ev),
      .st_we_i (wr && kind == K_IRQST && idx == IW'(u)),
      .en_we_i (wr && kind == K_IRQEN && idx == IW'(u)),
      .wdata_i (wdata_i[NB-1:0]),
      .st_o    (st[u]),
      .en_o    (en[u]),
      .irq_o   (irq_o[u])
    );
  end

  logic [31:0] sysc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sysc <= '0;
    else if (wr && kind == K_SYSC) sysc <= wdata_i & SYSC_MASK;
  end

  always_comb begin
    rdata_o = '0;
    unique case (kind)
      K_REV:   rdata_o = REV_VALUE;
      K_SYSC:  rdata_o = sysc;
      K_SSTAT: rdata_o = 32'd1;
      K_MSG, K_FSTAT, K_MSTAT:
        for (int n = 0; n < NUM_MBOX; n++)
          if (idx == IW'(n))
            rdata_o = (kind == K_MSG)   ? head[n] :
                      (kind == K_FSTAT) ? 32'(full[n]) : 32'(cnt[n]);
      K_IRQST, K_IRQEN:
        for (int u = 0; u < NUM_USERS; u++)
          if (idx == IW'(u))
            rdata_o = (kind == K_IRQST) ? 32'(st[u]) : 32'(en[u]);
      default: rdata_o = '0;
    endcase
  end

  AST_SYSC_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sysc & ~SYSC_MASK) == '0); // R3
  AST_DUAL_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && re_i && kind == K_MSG) |-> (unfull == '0)); // R12
endmodule

// File: tb/mbx_regbank_bench.sv
module mbx_regbank_bench;
  localparam logic [31:0] REV = 32'h0000_0021;
  localparam int NM = 6, NU = 4, D = 4;

  logic        clk = 0, rst_ni = 0;
  logic [8:0]  addr = '0;
  logic        we = 0, re = 0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  irq;

  always #5 clk = ~clk;

  mbx_regbank #(.NUM_MBOX(NM), .NUM_USERS(NU), .DEPTH(D), .ADDR_W(9), .REV_VALUE(REV))
    u_mbx_regbank (.clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we),
                   .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq));

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] q [NM][D];
  int          qc [NM];
  logic [11:0] mst [NU], men [NU];
  logic [31:0] msys;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [8:0] a);
    for (int n = 0; n < NM; n++) begin
      if (a == 9'(32'h40 + 4*n)) return (qc[n] > 0) ? q[n][0] : 32'd0;
      if (a == 9'(32'h80 + 4*n)) return (qc[n] == D) ? 32'd1 : 32'd0;
      if (a == 9'(32'hC0 + 4*n)) return 32'(qc[n]);
    end
    for (int u = 0; u < NU; u++) begin
      if (a == 9'(32'h100 + 8*u)) return 32'(mst[u]);
      if (a == 9'(32'h104 + 8*u)) return 32'(men[u]);
    end
    if (a == 9'h000) return REV;
    if (a == 9'h010) return msys;
    if (a == 9'h014) return 32'd1;
    return 32'd0;
  endfunction

  function automatic string tag_of(logic [8:0] a);
    if (a >= 9'h40 && a < 9'h58)   return "R4 msg";
    if (a >= 9'h80 && a < 9'h98)   return "R6 fstat";
    if (a >= 9'hC0 && a < 9'hD8)   return "R5 mstat";
    if (a >= 9'h100 && a < 9'h120) return (a[2]) ? "R10 mask" : "R8/R9 events";
    if (a == 9'h000) return "R2 rev";
    if (a == 9'h010) return "R3 sysc";
    if (a == 9'h014) return "R3 sstat";
    return "R11 unmapped";
  endfunction

  task automatic model_wr(logic [8:0] a, logic [31:0] d);
    for (int n = 0; n < NM; n++)
      if (a == 9'(32'h40 + 4*n) && qc[n] < D) begin
        q[n][qc[n]] = d; qc[n]++;
        for (int u = 0; u < NU; u++) mst[u][2*n] = 1'b1;
      end
    for (int u = 0; u < NU; u++) begin
      if (a == 9'(32'h100 + 8*u)) mst[u] &= ~d[11:0];
      if (a == 9'(32'h104 + 8*u)) men[u] = d[11:0];
    end
    if (a == 9'h010) msys = d & 32'h11;
  endtask

  task automatic model_rd(logic [8:0] a);
    for (int n = 0; n < NM; n++)
      if (a == 9'(32'h40 + 4*n) && qc[n] > 0) begin
        if (qc[n] == D)
          for (int u = 0; u < NU; u++) mst[u][2*n+1] = 1'b1;
        for (int k = 0; k < D-1; k++) q[n][k] = q[n][k+1];
        qc[n]--;
      end
  endtask

  task automatic chk_irq();
    logic [3:0] e;
    for (int u = 0; u < NU; u++) e[u] = |(mst[u] & men[u]);
    chk("R10 irq", 32'(irq), 32'(e));
  endtask

  task automatic op(bit w, bit r, logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    we = w; re = r; addr = a; wdata = d;
    #1;
    chk_irq();
    if (r && !w) chk(tag_of(a), rdata, exp_rd(a));
    if (w) model_wr(a, d);
    else if (r) model_rd(a);
    @(posedge clk);
    #1;
    we = 0; re = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int n = 0; n < NM; n++) qc[n] = 0;
    for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
    msys = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    for (int n = 0; n < NM; n++) op(0, 1, 9'(32'hC0 + 4*n), 0);
    for (int u = 0; u < NU; u++) begin
      op(0, 1, 9'(32'h100 + 8*u), 0);
      op(0, 1, 9'(32'h104 + 8*u), 0);
    end
    op(0, 1, 9'h010, 0);
    chk("R1 irq low", 32'(irq), 32'd0);

    // R2, R3, R11
    op(1, 0, 9'h000, 32'hDEAD_BEEF);
    op(0, 1, 9'h000, 0);
    op(1, 0, 9'h010, 32'hFFFF_FFFF);
    op(0, 1, 9'h010, 0);
    op(0, 1, 9'h014, 0);
    op(1, 0, 9'h1F0, 32'h1234);
    op(0, 1, 9'h1F0, 0);
    op(0, 1, 9'h030, 0);

    // R7 empty read, R4/R6/R7 fill and overflow on mailbox 2
    op(0, 1, 9'h48, 0);
    op(0, 1, 9'hC8, 0);
    for (int k = 0; k < D + 2; k++) op(1, 0, 9'h48, 32'hA000_0000 + 32'(k));
    op(0, 1, 9'h88, 0);
    op(0, 1, 9'hC8, 0);
    op(1, 0, 9'h104, 32'h0000_0030);  // user 0 masks bits 4,5 of mailbox 2
    op(0, 1, 9'h48, 0);               // full -> not full event (R8)
    op(0, 1, 9'h100, 0);
    op(0, 1, 9'h88, 0);
    for (int k = 0; k < D; k++) op(0, 1, 9'h48, 0);
    op(0, 1, 9'hC8, 0);

    // R9 write-one-to-clear, zeros hold
    op(1, 0, 9'h100, 32'h0000_0000);
    op(0, 1, 9'h100, 0);
    op(1, 0, 9'h100, 32'h0000_0010);
    op(0, 1, 9'h100, 0);
    op(1, 0, 9'h100, 32'hFFFF_FFFF);
    op(0, 1, 9'h100, 0);

    // R12 write and read strobes together
    op(1, 0, 9'h54, 32'h5555_0001);
    op(1, 1, 9'h54, 32'h5555_0002);
    op(0, 1, 9'hD4, 0);
    op(0, 1, 9'h54, 0);
    op(0, 1, 9'h54, 0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 12;
      int unsigned n = $urandom % NM;
      int unsigned u = $urandom % NU;
      logic [31:0] d = $urandom;
      case (r)
        0, 1, 2, 3: op(1, 0, 9'(32'h40 + 4*n), d);
        4, 5, 6:    op(0, 1, 9'(32'h40 + 4*n), 0);
        7:          op(0, 1, 9'((r & 1) ? 32'h80 + 4*n : 32'hC0 + 4*n), 0);
        8:          op(0, 1, 9'(32'hC0 + 4*n), 0);
        9:          op(1, 0, 9'(32'h100 + 8*u), d & 32'(~($urandom & 1) ? 32'hFFF : 32'h555));
        10:         op(1, 0, 9'(32'h104 + 8*u), d);
        default:    op(0, 1, 9'(32'h100 + 8*u), 0);
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule